// File: doc/BRIEF.md
# Dual-Strobe Host Register Port

This block is the host-facing register port of a signalling transceiver. A processor reaches five registers through a 4-bit bidirectional data bus, one chip select and one register-select bit. The two strobe pins take one of two meanings, set by a static mode input. In direction-and-strobe mode, one pin gives the transfer direction and the other is an active-high data strobe. In split-strobe mode, the two pins are separate active-low write and read strobes. The bus is split into an input, an output and an output enable, so that a pad ring can build the tri-state driver.

The pins are sampled in the block's own clock domain. A write is committed when the active strobe ends, using the last data seen while the strobe was active. The transmit and receive engines outside this block signal events on pulse inputs. The block records those events in status flags and pulls the open-drain interrupt line low when interrupts are enabled.

Top module: `hostport_regs`

## Requirements
- R1: After reset, tx_data, ctrl_a and ctrl_b are 0, the status flags and the write pointer are clear, d_oe is 0 and irq_drive is 0.
- R2: With mode_sep=0, pin_a is the direction (1 = read, 0 = write) and pin_b is an active-high data strobe. d_oe is 1 only while cs_n=0, pin_b=1 and pin_a=1.
- R3: While cs_n=1 the bus is never driven and no register changes because of the strobe pins.
- R4: With mode_sep=1, pin_a is an active-low write strobe and pin_b is an active-low read strobe. d_oe is 1 only while cs_n=0 and pin_b=0.
- R5: A write commits at the first clock edge where the write access is no longer active. It uses the data and rsel sampled in the last cycle the access was active. The new value is visible one clock after the strobe is released.
- R6: With rsel=0, a write loads tx_data and a read returns the receive register. The receive register loads rx_code on every clock where rx_valid=1.
- R7: With rsel=1, writes go to ctrl_a unless the pointer is set. A ctrl_a write sets the pointer to its bit 3. While the pointer is set, the next write loads ctrl_b and clears the pointer.
- R8: A read with rsel=1 returns status: bit0 = interrupt pending, bit1 = transmit event seen, bit2 = receive event seen, bit3 = 0.
- R9: When a status read ends, the pending, transmit and receive flags clear, and irq_drive returns to 0.
- R10: An event (tx_done or rx_valid) sets interrupt pending only while ctrl_a bit 2 is 1. irq_drive is 1 while pending is set and ctrl_a bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sep | input | 1 | Strobe style: 0 direction+strobe, 1 split strobes |
| cs_n | input | 1 | Active-low chip select |
| rsel | input | 1 | Register select bit |
| pin_a | input | 1 | Direction level, or active-low write strobe |
| pin_b | input | 1 | Data strobe, or active-low read strobe |
| d_in | input | 4 | Bus data from host |
| d_out | output | 4 | Bus data to host |
| d_oe | output | 1 | Bus output enable |
| tx_done | input | 1 | Transmit event pulse |
| rx_valid | input | 1 | Receive event pulse |
| rx_code | input | 4 | Received code, captured on rx_valid |
| tx_data | output | 4 | Transmit data register |
| ctrl_a | output | 4 | Control register A (bit 2 interrupt enable, bit 3 pointer) |
| ctrl_b | output | 4 | Control register B |
| irq_drive | output | 1 | Open-drain pull-low enable for the interrupt line |

## Verification
The bench strobes with chip select high. A design that lets the strobes through would drive the bus or overwrite tx_data. It also holds the write direction with the data strobe active in direction-and-strobe mode, where a bad decode would fight the host on the bus. The bench walks the control-register pointer through A, then B, then back to A. A pointer that fails to clear would send the third write to ctrl_b. It reads status twice to show the flags clear, and raises an event with interrupts disabled to show that pending stays clear.

// File: rtl/hostport_regs.sv
module hostport_regs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sep,
  input  logic          cs_n,
  input  logic          rsel,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  output logic [DW-1:0] tx_data,
  output logic [DW-1:0] ctrl_a,
  output logic [DW-1:0] ctrl_b,
  output logic          irq_drive
);
  localparam int IEN = 2;
  localparam int PTR = DW - 1;

  logic wact, ract, wact_q, ract_q, wsel_q, rsel_q, ptr;
  logic commit, rclr, pend, txf, rxf;
  logic [DW-1:0] wdat_q, rx_reg, status;

  assign wact = !cs_n && (mode_sep ? !pin_a : (!pin_a && pin_b));
  assign ract = !cs_n && (mode_sep ? !pin_b : (pin_a && pin_b));
  assign commit = wact_q && !wact;
  assign rclr = ract_q && !ract && rsel_q;

  assign status = {{(DW-3){1'b0}}, rxf, txf, pend};
  assign d_out = rsel ? status : rx_reg;
  assign d_oe = ract;
  assign irq_drive = pend && ctrl_a[IEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_q <= 1'b0;
      ract_q <= 1'b0;
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
      wdat_q <= '0;
      tx_data <= '0;
      ctrl_a <= '0;
      ctrl_b <= '0;
      ptr <= 1'b0;
      rx_reg <= '0;
      pend <= 1'b0;
      txf <= 1'b0;
      rxf <= 1'b0;
    end else begin
      wact_q <= wact;
      ract_q <= ract;
      if (wact) begin
        wdat_q <= d_in;
        wsel_q <= rsel;
      end
      if (ract) rsel_q <= rsel;
      if (commit) begin
        if (!wsel_q) tx_data <= wdat_q;
        else if (ptr) begin
          ctrl_b <= wdat_q;
          ptr <= 1'b0;
        end else begin
          ctrl_a <= wdat_q;
          ptr <= wdat_q[PTR];
        end
      end
      if (rx_valid) rx_reg <= rx_code;
      txf <= (txf && !rclr) || tx_done;
      rxf <= (rxf && !rclr) || rx_valid;
      pend <= (pend && !rclr) || ((tx_done || rx_valid) && ctrl_a[IEN]);
    end
  end
endmodule

module hostport_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_sep,
  input logic       cs_n,
  input logic       pin_a,
  input logic       pin_b,
  input logic       d_oe,
  input logic       tx_done,
  input logic       rx_valid,
  input logic [3:0] ctrl_a,
  input logic       irq_drive
);
  // R3
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !d_oe);
  // R2
  dir_mode_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sep && d_oe) |-> (pin_a && pin_b));
  // R4
  split_mode_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sep && d_oe) |-> !pin_b);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_done || rx_valid) && ctrl_a[2]) |=> (irq_drive || !ctrl_a[2]));
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !irq_drive);
endmodule

bind hostport_regs hostport_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n), .pin_a(pin_a),
  .pin_b(pin_b), .d_oe(d_oe), .tx_done(tx_done), .rx_valid(rx_valid),
  .ctrl_a(ctrl_a), .irq_drive(irq_drive)
);

// File: tb/hostport_regs_tb.sv
module hostport_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sep = 1'b0, cs_n = 1'b1, rsel = 1'b0, pin_a = 1'b1, pin_b = 1'b0;
  logic [3:0] d_in = '0, rx_code = '0;
  logic tx_done = 1'b0, rx_valid = 1'b0;
  logic [3:0] d_out, tx_data, ctrl_a, ctrl_b;
  logic d_oe, irq_drive;
  int n_chk = 0, n_bad = 0;
  logic [3:0] rv;

  always #10 clk = ~clk;

  hostport_regs dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n), .rsel(rsel),
    .pin_a(pin_a), .pin_b(pin_b), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .tx_done(tx_done), .rx_valid(rx_valid), .rx_code(rx_code),
    .tx_data(tx_data), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq_drive(irq_drive)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1;
    pin_a = 1'b1;
    pin_b = mode_sep ? 1'b1 : 1'b0;
  endtask

  task automatic host_wr(input logic rs, input logic [3:0] d);
    @(negedge clk);
    cs_n = 1'b0; rsel = rs; d_in = d;
    if (mode_sep) pin_a = 1'b0; else begin pin_a = 1'b0; pin_b = 1'b1; end
    repeat (2) @(negedge clk);
    idle();
    d_in = 4'hF;
    @(negedge clk);
  endtask

  task automatic host_rd(input logic rs, output logic [3:0] d);
    @(negedge clk);
    cs_n = 1'b0; rsel = rs;
    if (mode_sep) pin_b = 1'b0; else begin pin_a = 1'b1; pin_b = 1'b1; end
    @(negedge clk);
    d = d_out;
    chk("R2/R4 read drives bus", {3'b0, d_oe}, 4'h1);
    idle();
    @(negedge clk);
  endtask

  task automatic pulse_rx(input logic [3:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_code = c;
    @(negedge clk); rx_valid = 1'b0; rx_code = 4'h0;
  endtask

  task automatic t_reset();
    chk("R1 tx_data", tx_data, 4'h0);
    chk("R1 ctrl_a", ctrl_a, 4'h0);
    chk("R1 ctrl_b", ctrl_b, 4'h0);
    chk("R1 oe/irq", {2'b0, d_oe, irq_drive}, 4'h0);
  endtask

  task automatic t_dir_mode();
    host_wr(1'b0, 4'h5);
    chk("R5 R6 tx write", tx_data, 4'h5);
    @(negedge clk); pin_a = 1'b0; pin_b = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk("R3 no drive deselected", {3'b0, d_oe}, 4'h0);
    idle(); @(negedge clk);
    chk("R3 tx untouched", tx_data, 4'h5);
    cs_n = 1'b0; rsel = 1'b0; pin_a = 1'b0; pin_b = 1'b1; d_in = 4'h7;
    @(negedge clk);
    chk("R2 write holds bus off", {3'b0, d_oe}, 4'h0);
    idle(); @(negedge clk);
    chk("R5 second tx write", tx_data, 4'h7);
    pulse_rx(4'h9);
    host_rd(1'b0, rv);
    chk("R6 rx read", rv, 4'h9);
  endtask

  task automatic t_pointer();
    host_wr(1'b1, 4'h8);
    chk("R7 ctrl_a arm", ctrl_a, 4'h8);
    host_wr(1'b1, 4'h3);
    chk("R7 ctrl_b load", ctrl_b, 4'h3);
    chk("R7 ctrl_a kept", ctrl_a, 4'h8);
    host_wr(1'b1, 4'h4);
    chk("R7 back to ctrl_a", ctrl_a, 4'h4);
    chk("R7 ctrl_b kept", ctrl_b, 4'h3);
  endtask

  task automatic t_status();
    host_rd(1'b1, rv);
    chk("R8 R10 rx flag, no pend while disabled", rv, 4'h4);
    host_rd(1'b1, rv);
    chk("R9 flags cleared", rv, 4'h0);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk("R10 irq asserted", {3'b0, irq_drive}, 4'h1);
    host_rd(1'b1, rv);
    chk("R8 tx+pend", rv, 4'h3);
    chk("R9 irq released", {3'b0, irq_drive}, 4'h0);
  endtask

  task automatic t_split_mode();
    @(negedge clk); mode_sep = 1'b1; idle();
    host_wr(1'b0, 4'hA);
    chk("R4 R5 split write", tx_data, 4'hA);
    @(negedge clk); cs_n = 1'b0; rsel = 1'b0; pin_a = 1'b0; d_in = 4'h2;
    @(negedge clk);
    chk("R4 write strobe no drive", {3'b0, d_oe}, 4'h0);
    idle(); @(negedge clk);
    chk("R4 split write 2", tx_data, 4'h2);
    pulse_rx(4'h3);
    host_rd(1'b0, rv);
    chk("R4 R6 split rx read", rv, 4'h3);
    chk("R9 irq from rx pending", {3'b0, irq_drive}, 4'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_dir_mode();
    t_pointer();
    t_status();
    t_split_mode();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule